// File: doc/BRIEF.md
# Fractional M/N Audio Clock Divider

This block derives an audio master clock from a fast system clock. A phase accumulator adds a step value M on every fast clock and wraps modulo a period N. The resulting output averages M rising edges for every N input cycles. The high phase of the output lasts while the accumulator sits below a duty threshold D. A two-bit output select either passes an external reference clock straight to the output or routes the divided clock there. A separate bit drives a parent-select line toward an upstream source mux.

Software programs the block through two 32-bit registers on a simple single-cycle write bus. Reads are combinational. The divider register holds N, M, the output select and the parent select. The auxiliary register holds D and two enable flags. While the D-enable flag is clear, any write to the auxiliary register loads D with half of the current N and discards the written D. That update happens only on such a write. The two flag bits come back swapped on reads, while writes use their nominal positions.

Top module: `mnAudioDiv`

## Requirements
- R1: After reset both registers read 0, the divider is stopped and `mclkOut` follows `extRefClk`.
- R2: Register 0 (`busAddr`=0) holds N at bits 12:0, M at bits 21:13, the output select at bits 30:29 and the parent select at bit 31, and bits 28:22 read 0.
- R3: With output select 3, the number of rising edges of `mclkOut` over W fast clock cycles is W*M/N (integer part), within two edges.
- R4: A write to register 0 with N below 2*M stores N as 2*M.
- R5: Output select bit 30 routes the divided clock (1) or `extRefClk` (0) to `mclkOut`. Bit 29 runs the accumulator. With bits 30:29 = 0 or 1 the output follows `extRefClk`. With 2 the output is held low. With 3 it is the divided clock.
- R6: A write to register 1 (`busAddr`=1) with bit 30 clear loads D (bits 12:0) with the current N divided by two (rounded down), ignoring the written D.
- R7: A write to register 1 with bit 30 set stores the written D unchanged.
- R8: D changes only on a register 1 write; a register 0 write that changes N leaves D as it was.
- R9: Reading register 1 returns the written bit 31 at bit 30 and the written bit 30 at bit 31.
- R10: Register 1 bit 31 has no effect on the N and M fields of register 0.
- R11: `parentSel` equals register 0 bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock driving the accumulator and registers |
| rstN | input | 1 | Active-low synchronous reset |
| extRefClk | input | 1 | External reference clock for passthrough |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 1 | Register select: 0 divider, 1 auxiliary |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data of the selected register |
| mclkOut | output | 1 | Audio master clock output |
| parentSel | output | 1 | Upstream parent source select |

## Verification
The hardest behaviour to reach from the ports is the write-only nature of the D derivation. D must be seen to keep a value computed from an old N after N has changed. The stimulus writes register 1 with auto mode, then rewrites register 0 with a new N, and reads D back before and after a second register 1 write. The rate checks go through a table of M/N pairs. The table includes a clamped pair and the extremes N=2M and N much larger than M. Edges are counted over windows long enough that the allowed two-edge tolerance is a small fraction of the count.

// File: rtl/mnDivPkg.sv
package mnDivPkg;
  localparam int REG_W      = 32;
  localparam int SEL_LSB    = 29;
  localparam int PARENT_BIT = 31;
  localparam int DEN_BIT    = 30;
  localparam int NEN_BIT    = 31;

  typedef struct packed {
    logic accClear;
    logic accRun;
  } divStrobe_t;
endpackage

// File: rtl/mnDivCtrl.sv
module mnDivCtrl
  import mnDivPkg::*;
#(
  parameter int N_W = 13,
  parameter int M_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrEn,
  input  logic             busAddr,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  output logic [N_W-1:0]   nVal,
  output logic [M_W-1:0]   mVal,
  output logic [N_W-1:0]   dVal,
  output logic [1:0]       outSel,
  output logic             parentSel,
  output divStrobe_t       strobe
);
  localparam int M_LSB = N_W;
  localparam int M_MSB = N_W + M_W - 1;

  logic wrMain, wrAux;
  logic [N_W-1:0] nQ, dQ, nWr, nClamped;
  logic [M_W-1:0] mQ, mWr;
  logic [N_W:0]   twoM;
  logic [1:0]     selQ;
  logic           parentQ, dEnQ, nEnQ;

  assign wrMain = busWrEn && !busAddr;
  assign wrAux  = busWrEn && busAddr;
  assign nWr    = busWdata[N_W-1:0];
  assign mWr    = busWdata[M_MSB:M_LSB];
  assign twoM   = (N_W+1)'({mWr, 1'b0});
  assign nClamped = ({1'b0, nWr} < twoM) ? twoM[N_W-1:0] : nWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nQ <= '0; mQ <= '0; selQ <= '0; parentQ <= 1'b0;
      dQ <= '0; dEnQ <= 1'b0; nEnQ <= 1'b0;
    end else begin
      if (wrMain) begin
        nQ      <= nClamped;
        mQ      <= mWr;
        selQ    <= busWdata[SEL_LSB+1:SEL_LSB];
        parentQ <= busWdata[PARENT_BIT];
      end
      if (wrAux) begin
        dEnQ <= busWdata[DEN_BIT];
        nEnQ <= busWdata[NEN_BIT];
        dQ   <= busWdata[DEN_BIT] ? busWdata[N_W-1:0] : (nQ >> 1);
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (!busAddr) begin
      busRdata[N_W-1:0]             = nQ;
      busRdata[M_MSB:M_LSB]         = mQ;
      busRdata[SEL_LSB+1:SEL_LSB]   = selQ;
      busRdata[PARENT_BIT]          = parentQ;
    end else begin
      busRdata[N_W-1:0] = dQ;
      busRdata[NEN_BIT] = dEnQ;
      busRdata[DEN_BIT] = nEnQ;
    end
  end

  assign nVal      = nQ;
  assign mVal      = mQ;
  assign dVal      = dQ;
  assign outSel    = selQ;
  assign parentSel = parentQ;
  assign strobe.accClear = wrMain;
  assign strobe.accRun   = selQ[0];

  a_r4_clamp: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, nQ} >= (N_W+1)'({mQ, 1'b0}));
  a_r6_d_auto: assert property (@(posedge clk) disable iff (!rstN)
    (wrAux && !busWdata[DEN_BIT]) |=> (dQ == ($past(nQ) >> 1)));
  a_r8_d_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrAux |=> $stable(dQ));
endmodule

// File: rtl/mnDivAccum.sv
module mnDivAccum
  import mnDivPkg::*;
#(
  parameter int N_W = 13,
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rstN,
  input  divStrobe_t     strobe,
  input  logic [N_W-1:0] nVal,
  input  logic [M_W-1:0] mVal,
  input  logic [N_W-1:0] dVal,
  output logic           divClk
);
  logic [N_W-1:0] accQ, accNext;
  logic [N_W:0]   sum, diff;
  logic           divClkQ;

  always_comb begin
    sum     = {1'b0, accQ} + (N_W+1)'(mVal);
    diff    = sum - {1'b0, nVal};
    accNext = (sum >= {1'b0, nVal}) ? diff[N_W-1:0] : sum[N_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.accClear || !strobe.accRun) begin
      accQ    <= '0;
      divClkQ <= 1'b0;
    end else begin
      accQ    <= accNext;
      divClkQ <= accNext < dVal;
    end
  end

  assign divClk = divClkQ;

  a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rstN)
    (nVal != '0) |-> (accQ < nVal));
  a_r5_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accRun |=> !divClkQ);
endmodule

// File: rtl/mnAudioDiv.sv
module mnAudioDiv
  import mnDivPkg::*;
#(
  parameter int N_W = 13,
  parameter int M_W = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extRefClk,
  input  logic        busWrEn,
  input  logic        busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        mclkOut,
  output logic        parentSel
);
  logic [N_W-1:0] nVal, dVal;
  logic [M_W-1:0] mVal;
  logic [1:0]     outSel;
  logic           divClk;
  divStrobe_t     strobe;

  mnDivCtrl #(.N_W(N_W), .M_W(M_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .nVal(nVal), .mVal(mVal),
    .dVal(dVal), .outSel(outSel), .parentSel(parentSel), .strobe(strobe)
  );

  mnDivAccum #(.N_W(N_W), .M_W(M_W)) u_accum (
    .clk(clk), .rstN(rstN), .strobe(strobe), .nVal(nVal), .mVal(mVal),
    .dVal(dVal), .divClk(divClk)
  );

  assign mclkOut = outSel[1] ? divClk : extRefClk;
endmodule

// File: tb/mnAudioDiv_tb.sv
module mnAudioDiv_tb;
  logic clk = 1'b0, rstN = 1'b0, extRefClk = 1'b0, busWrEn = 1'b0, busAddr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic mclkOut, parentSel;
  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mnAudioDiv u_dut (
    .clk(clk), .rstN(rstN), .extRefClk(extRefClk), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .mclkOut(mclkOut), .parentSel(parentSel)
  );

  // {M, N, window}
  localparam logic [47:0] VECS [6] = '{
    {16'd1,   16'd2,    16'd2000},
    {16'd3,   16'd10,   16'd3000},
    {16'd7,   16'd2500, 16'd25000},
    {16'd100, 16'd333,  16'd3000},
    {16'd511, 16'd1022, 16'd2000},
    {16'd5,   16'd8,    16'd2000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic countEdges(input int w, output int c);
    logic prev;
    c = 0;
    @(negedge clk);
    prev = mclkOut;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (mclkOut && !prev) c++;
      prev = mclkOut;
    end
  endtask

  function automatic logic [31:0] mainWord(input logic par, input logic [1:0] sel,
                                           input int m, input int n);
    return {par, sel, 7'd0, 9'(m), 13'(n)};
  endfunction

  initial begin
    #(8 * 190000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    if (!done) $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int c, m, n, w, nExp, eExp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, r); chk("R1 reg0 reset", r, 32'h0);
    rd(1'b1, r); chk("R1 reg1 reset", r, 32'h0);
    extRefClk = 1'b1; #1; chk("R1 passthrough high", 32'(mclkOut), 32'd1);
    extRefClk = 1'b0; #1; chk("R1 passthrough low", 32'(mclkOut), 32'd0);

    // R3/R4/R6 rate table
    for (int v = 0; v < 6; v++) begin
      m = int'(VECS[v][47:32]); n = int'(VECS[v][31:16]); w = int'(VECS[v][15:0]);
      nExp = (n < 2 * m) ? 2 * m : n;
      wr(1'b0, mainWord(1'b0, 2'd3, m, n));
      wr(1'b1, 32'h0000_1fff);
      rd(1'b0, r); chk("R4 R2 N readback", 32'(r[12:0]), 32'(nExp));
      chk("R2 M readback", 32'(r[21:13]), 32'(m));
      rd(1'b1, r); chk("R6 D auto", 32'(r[12:0]), 32'(nExp / 2));
      countEdges(w, c);
      eExp = (w * m) / nExp;
      nChecks++;
      if (c - eExp > 2 || eExp - c > 2) begin
        nFail++;
        $display("FAIL R3 rate M=%0d N=%0d actual=%0d expected=%0d", m, nExp, c, eExp);
      end
    end

    // R2 reserved bits, R11 parent select
    wr(1'b0, 32'hffff_ffff);
    rd(1'b0, r); chk("R2 reserved zero", 32'(r[28:22]), 32'd0);
    chk("R11 parentSel high", 32'(parentSel), 32'd1);
    wr(1'b0, mainWord(1'b0, 2'd3, 2, 20));
    chk("R11 parentSel low", 32'(parentSel), 32'd0);

    // R8: D held across N change, updated on next reg1 write
    wr(1'b1, 32'h0);
    rd(1'b1, r); chk("R8 D before", 32'(r[12:0]), 32'd10);
    wr(1'b0, mainWord(1'b0, 2'd3, 2, 100));
    rd(1'b1, r); chk("R8 D unchanged after N write", 32'(r[12:0]), 32'd10);
    wr(1'b1, 32'h0);
    rd(1'b1, r); chk("R8 D after reg1 write", 32'(r[12:0]), 32'd50);

    // R7 explicit D
    wr(1'b1, 32'h4000_007b);
    rd(1'b1, r); chk("R7 D kept", 32'(r[12:0]), 32'd123);
    // R9 swap: written bit30=1,bit31=0 -> read bit31=1,bit30=0
    chk("R9 swap a", 32'(r[31:30]), 32'd2);
    // R10 and R9: written bit31=1,bit30=0
    wr(1'b1, 32'h8000_0005);
    rd(1'b1, r); chk("R9 swap b", 32'(r[31:30]), 32'd1);
    chk("R6 D auto ignores written", 32'(r[12:0]), 32'd50);
    rd(1'b0, r); chk("R10 N untouched", 32'(r[12:0]), 32'd100);
    chk("R10 M untouched", 32'(r[21:13]), 32'd2);

    // R5 select 2: held low
    wr(1'b0, mainWord(1'b0, 2'd2, 1, 2));
    wr(1'b1, 32'h0);
    countEdges(200, c); chk("R5 sel2 no edges", 32'(c), 32'd0);
    chk("R5 sel2 low", 32'(mclkOut), 32'd0);
    // R5 select 1: passthrough
    wr(1'b0, mainWord(1'b0, 2'd1, 1, 2));
    extRefClk = 1'b1; #1; chk("R5 sel1 passthrough", 32'(mclkOut), 32'd1);
    extRefClk = 1'b0; #1; chk("R5 sel1 passthrough low", 32'(mclkOut), 32'd0);
    // R5 select 0: passthrough
    wr(1'b0, mainWord(1'b0, 2'd0, 1, 2));
    extRefClk = 1'b1; #1; chk("R5 sel0 passthrough", 32'(mclkOut), 32'd1);
    extRefClk = 1'b0;
    // R5 select 3 resumes dividing
    wr(1'b0, mainWord(1'b0, 2'd3, 1, 2));
    countEdges(400, c);
    nChecks++;
    if (c < 198 || c > 202) begin
      nFail++;
      $display("FAIL R5 sel3 edges actual=%0d expected=200", c);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule